// File: doc/BRIEF.md
# Single-Level Call/Return Program Sequencer

This block produces the instruction fetch address for a small 4-bit controller. It holds a 10-bit program counter, a 1-bit stack pointer and one 10-bit return-address register. Every cycle it receives a decoded sequencing operation (advance, jump, call or return), the byte length of the current instruction and a 10-bit operand address. From these it computes the next fetch address. Instruction decode, the ALU, flags and program memory are outside this block. Conditional jumps reach it as a plain jump once their condition has been resolved.

The return stack is only one entry deep. A second nested call, or a return with nothing saved, is a stack fault. The block answers a fault with a one-cycle system-reset pulse, which brings the program counter and stack pointer back to zero. No reset, power-up or fault, touches the contents of the return register. The register's low byte is also a data-memory location, reached through a byte-wide data port. Writing that byte zeroes the upper return bits and raises an invalid flag, which stays set until the next call.

Top module: `callret_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to fetch address 000h, stack pointer 0, no reset request, and the return-invalid flag set.
- R2: With op code 00 (advance), the fetch address grows by `len_i` (0 to 3) modulo 1024 and the stack pointer holds.
- R3: With op code 01 (jump), the fetch address becomes `opnd_i` and the stack pointer holds.
- R4: With op code 10 (call) and stack pointer 0, the return register takes the current fetch address plus `len_i`, the fetch address becomes `opnd_i`, the stack pointer becomes 1 and the invalid flag clears.
- R5: With op code 11 (return) and stack pointer 1, the fetch address becomes the saved return address, the stack pointer becomes 0 and the return register keeps its value.
- R6: A call with stack pointer 1, or a return with stack pointer 0, leaves the fetch address, stack pointer and return register unchanged and raises `sysrst_o` for exactly the next cycle. At the edge that ends that cycle, the fetch address goes to 000h and the stack pointer to 0, whatever op is applied during it.
- R7: Neither `rst_n` nor the stack-fault reset alters the return register. Its low byte reads back unchanged through the data port.
- R8: `drdata_o` shows the return register's low 8 bits without delay. A write (`dwr_i` high) replaces them with `dwdata_i`, clears the upper 2 bits and sets `ret_invalid_o` until the next executed call. When a call is executed in the same cycle as a write, the call's save wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Sequencing op: 00 advance, 01 jump, 10 call, 11 return |
| len_i | input | 2 | Byte length of the current instruction |
| opnd_i | input | 10 | Operand target address for jump and call |
| dwr_i | input | 1 | Data-port write strobe for the aliased byte |
| dwdata_i | input | 8 | Data-port write byte |
| drdata_o | output | 8 | Data-port read byte (low byte of return register) |
| fetch_addr_o | output | 10 | Current program counter / fetch address |
| sp_o | output | 1 | Stack pointer |
| sysrst_o | output | 1 | One-cycle system-reset request after a stack fault |
| ret_invalid_o | output | 1 | Return address not trustworthy since last call |

## Verification
The assertions assume that the return register is never read as an address while it still holds power-up garbage. Stack-stability checks are therefore guarded by the invalid flag, and a return with stack pointer 1 can only follow a real call. The stimulus keeps `op_i` and `len_i` defined on every cycle, including cycles in reset. It reads the data port only after a call or write has given the register a known value. It sweeps every jump target, every instruction length, call/return pairs over a spread of addresses, all 256 data bytes, and both fault kinds with each op applied during the reset pulse.

// File: rtl/callret_pkg.sv
package callret_pkg;
   typedef enum logic [1:0] {
      SEQ_ADV  = 2'b00,
      SEQ_JMP  = 2'b01,
      SEQ_CALL = 2'b10,
      SEQ_RET  = 2'b11
   } seq_op_e;
endpackage

// File: rtl/callret_stack.sv
module callret_stack
   import callret_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  seq_op_e op_i,
   output logic    sp_o,
   output logic    fault_o,
   output logic    exec_o
);
   logic sp_q, fault_q, fault_req;

   assign fault_req = !fault_q &&
                      ((op_i == SEQ_CALL && sp_q) || (op_i == SEQ_RET && !sp_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q    <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= fault_req;
         if (fault_q)
            sp_q <= 1'b0;
         else if (!fault_req) begin
            if (op_i == SEQ_CALL)
               sp_q <= 1'b1;
            else if (op_i == SEQ_RET)
               sp_q <= 1'b0;
         end
      end
   end

   assign sp_o    = sp_q;
   assign fault_o = fault_q;
   assign exec_o  = !fault_q && !fault_req;

   // R6: fault request is a single-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |=> !fault_q);
   // R6: underflow on return raises the request
   a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_q && op_i == SEQ_RET && !sp_q) |=> fault_q);
endmodule

// File: rtl/callret_pc.sv
module callret_pc
   import callret_pkg::*;
#(
   parameter int PC_W  = 10,
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_op_e          op_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [PC_W-1:0]  opnd_i,
   input  logic [PC_W-1:0]  ret_addr_i,
   input  logic             exec_i,
   input  logic             clear_i,
   output logic [PC_W-1:0]  pc_o,
   output logic [PC_W-1:0]  link_o
);
   logic [PC_W-1:0] pc_q, pc_d;

   assign link_o = pc_q + PC_W'(len_i);

   always_comb begin
      pc_d = pc_q;
      if (clear_i)
         pc_d = '0;
      else if (exec_i) begin
         unique case (op_i)
            SEQ_ADV:  pc_d = link_o;
            SEQ_JMP:  pc_d = opnd_i;
            SEQ_CALL: pc_d = opnd_i;
            SEQ_RET:  pc_d = ret_addr_i;
            default:  pc_d = pc_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc_q <= '0;
      else
         pc_q <= pc_d;
   end

   assign pc_o = pc_q;

   // R3: an executed jump lands on the operand
   a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == SEQ_JMP) |=> pc_q == $past(opnd_i));
   // R6: a held (non-executed, non-clearing) cycle keeps the counter
   a_r6_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_i && !clear_i) |=> $stable(pc_q));
endmodule

// File: rtl/callret_retreg.sv
module callret_retreg #(
   parameter int PC_W   = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_en_i,
   input  logic [PC_W-1:0]   save_val_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [PC_W-1:0]   ret_addr_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              invalid_o
);
   localparam int HI_W = PC_W - DATA_W;

   logic [DATA_W-1:0] lo_q;
   logic              inv_q;

   always_ff @(posedge clk) begin
      if (save_en_i)
         lo_q <= save_val_i[DATA_W-1:0];
      else if (wr_en_i)
         lo_q <= wr_data_i;
   end

   generate
      if (HI_W > 0) begin : g_hi
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk) begin
            if (save_en_i)
               hi_q <= save_val_i[PC_W-1:DATA_W];
            else if (wr_en_i)
               hi_q <= '0;
         end
         assign ret_addr_o = {hi_q, lo_q};

         // R8: a data write that is not overridden zeroes the upper bits
         a_r8_hi_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !save_en_i) |=> hi_q == '0);
      end else begin : g_nohi
         assign ret_addr_o = lo_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         inv_q <= 1'b1;
      else if (save_en_i)
         inv_q <= 1'b0;
      else if (wr_en_i)
         inv_q <= 1'b1;
   end

   assign rd_data_o = lo_q;
   assign invalid_o = inv_q;

   // R4: a save marks the address trustworthy and captures the value
   a_r4_save_capture: assert property (@(posedge clk) disable iff (!rst_n)
      save_en_i |=> (!inv_q && ret_addr_o == $past(save_val_i)));
endmodule

// File: rtl/callret_seq.sv
module callret_seq
   import callret_pkg::*;
#(
   parameter int PC_W   = 10,
   parameter int LEN_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [PC_W-1:0]   opnd_i,
   input  logic              dwr_i,
   input  logic [DATA_W-1:0] dwdata_i,
   output logic [DATA_W-1:0] drdata_o,
   output logic [PC_W-1:0]   fetch_addr_o,
   output logic              sp_o,
   output logic              sysrst_o,
   output logic              ret_invalid_o
);
   generate
      if (PC_W < DATA_W) begin : g_bad_width
         $error("callret_seq: PC_W must be at least DATA_W");
      end
      if (LEN_W < 1 || LEN_W >= PC_W) begin : g_bad_len
         $error("callret_seq: LEN_W out of range");
      end
   endgenerate

   seq_op_e         op;
   logic            exec, fault, sp;
   logic [PC_W-1:0] ret_addr, link, pc;

   assign op = seq_op_e'(op_i);

   callret_stack u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .sp_o    (sp),
      .fault_o (fault),
      .exec_o  (exec)
   );

   callret_pc #(.PC_W(PC_W), .LEN_W(LEN_W)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .len_i      (len_i),
      .opnd_i     (opnd_i),
      .ret_addr_i (ret_addr),
      .exec_i     (exec),
      .clear_i    (fault),
      .pc_o       (pc),
      .link_o     (link)
   );

   callret_retreg #(.PC_W(PC_W), .DATA_W(DATA_W)) u_ret (
      .clk        (clk),
      .rst_n      (rst_n),
      .save_en_i  (exec && op == SEQ_CALL),
      .save_val_i (link),
      .wr_en_i    (dwr_i),
      .wr_data_i  (dwdata_i),
      .ret_addr_o (ret_addr),
      .rd_data_o  (drdata_o),
      .invalid_o  (ret_invalid_o)
   );

   assign fetch_addr_o = pc;
   assign sp_o         = sp;
   assign sysrst_o     = fault;

   // R1: reset state
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (fetch_addr_o == '0 && !sp_o && !sysrst_o && ret_invalid_o));
   // R2: advance adds the length
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!sysrst_o && op_i == 2'b00) |=> fetch_addr_o == $past(fetch_addr_o + PC_W'(len_i)));
   // R4: executed call
   a_r4_call: assert property (@(posedge clk) disable iff (!rst_n)
      (!sysrst_o && op_i == 2'b10 && !sp_o) |=> (sp_o && fetch_addr_o == $past(opnd_i)));
   // R5: executed return
   a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
      (!sysrst_o && op_i == 2'b11 && sp_o) |=> (!sp_o && fetch_addr_o == $past(ret_addr)));
   // R6: overflow on call raises the request
   a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!sysrst_o && op_i == 2'b10 && sp_o) |=> sysrst_o);
   // R6: the request clears counter and pointer
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sysrst_o |=> (fetch_addr_o == '0 && !sp_o));
   // R7: the fault reset leaves the return register alone
   a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (sysrst_o && !dwr_i && !ret_invalid_o) |=> $stable(ret_addr));
   // R8: a write that is not overridden shows up on the read port
   a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr_i && !(exec && op == SEQ_CALL)) |=> (ret_invalid_o && drdata_o == $past(dwdata_i)));
endmodule

// File: tb/callret_seq_tb.sv
module callret_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_i = 2'b00;
   logic [1:0] len_i = 2'b00;
   logic [9:0] opnd_i = '0;
   logic       dwr_i = 1'b0;
   logic [7:0] dwdata_i = '0;
   logic [7:0] drdata_o;
   logic [9:0] fetch_addr_o;
   logic       sp_o, sysrst_o, ret_invalid_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [9:0] m_pc, m_ret;
   logic       m_sp, m_flt, m_inv, m_known;

   always #4 clk = ~clk;

   callret_seq u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .len_i(len_i), .opnd_i(opnd_i),
      .dwr_i(dwr_i), .dwdata_i(dwdata_i), .drdata_o(drdata_o),
      .fetch_addr_o(fetch_addr_o), .sp_o(sp_o), .sysrst_o(sysrst_o),
      .ret_invalid_o(ret_invalid_o)
   );

   task automatic chk(input string tag, input string what, input logic [9:0] act, input logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "fetch", fetch_addr_o, m_pc);
      chk(tag, "sp", {9'd0, sp_o}, {9'd0, m_sp});
      chk(tag, "sysrst", {9'd0, sysrst_o}, {9'd0, m_flt});
      chk(tag, "invalid", {9'd0, ret_invalid_o}, {9'd0, m_inv});
      if (m_known)
         chk(tag, "rdata", {2'b00, drdata_o}, {2'b00, m_ret[7:0]});
   endtask

   // called at a negative edge; returns at the next negative edge
   task automatic step(input logic [1:0] op, input logic [1:0] len, input logic [9:0] a,
                       input logic w, input logic [7:0] wd, input string tag);
      logic callx;
      callx = 1'b0;
      op_i = op; len_i = len; opnd_i = a; dwr_i = w; dwdata_i = wd;
      @(posedge clk);
      if (m_flt) begin
         m_pc = '0; m_sp = 1'b0; m_flt = 1'b0;
      end else if ((op == 2'b10 && m_sp) || (op == 2'b11 && !m_sp)) begin
         m_flt = 1'b1;
      end else begin
         case (op)
            2'b00: m_pc = m_pc + 10'(len);
            2'b01: m_pc = a;
            2'b10: begin
               m_ret = m_pc + 10'(len); m_pc = a; m_sp = 1'b1;
               m_inv = 1'b0; m_known = 1'b1; callx = 1'b1;
            end
            default: begin m_pc = m_ret; m_sp = 1'b0; end
         endcase
      end
      if (w && !callx) begin
         m_ret = {2'b00, wd}; m_inv = 1'b1; m_known = 1'b1;
      end
      @(negedge clk);
      dwr_i = 1'b0;
      check_all(tag);
   endtask

   task automatic do_reset(input string tag);
      rst_n = 1'b0; op_i = 2'b00; dwr_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_pc = '0; m_sp = 1'b0; m_flt = 1'b0; m_inv = 1'b1;
      check_all(tag);
   endtask

   initial begin
      m_known = 1'b0; m_ret = '0;
      @(negedge clk);
      do_reset("R1");

      // R3: every jump target
      for (int a = 0; a < 1024; a++)
         step(2'b01, 2'(a), 10'(a), 1'b0, 8'h00, "R3");

      // R2: every length from many start points, including wrap
      for (int a = 0; a < 1024; a += 13) begin
         step(2'b01, 2'd0, 10'(1023 - a), 1'b0, 8'h00, "R3");
         for (int l = 0; l < 4; l++)
            step(2'b00, 2'(l), 10'h3ff, 1'b0, 8'h00, "R2");
      end

      // R4 / R5: call and return pairs
      for (int a = 0; a < 1024; a += 7) begin
         for (int l = 0; l < 4; l++) begin
            step(2'b01, 2'd0, 10'(a), 1'b0, 8'h00, "R3");
            step(2'b10, 2'(l), 10'(1023 - a), 1'b0, 8'h00, "R4");
            step(2'b00, 2'd2, 10'h000, 1'b0, 8'h00, "R2");
            step(2'b11, 2'd1, 10'h155, 1'b0, 8'h00, "R5");
            step(2'b00, 2'd0, 10'h000, 1'b0, 8'h00, "R5");
         end
      end

      // R8: all data bytes, with upper bits cleared and invalid flag
      step(2'b01, 2'd0, 10'h200, 1'b0, 8'h00, "R3");
      step(2'b10, 2'd3, 10'h3c0, 1'b0, 8'h00, "R4");
      for (int d = 0; d < 256; d++)
         step(2'b00, 2'd1, 10'h000, 1'b1, 8'(d), "R8");
      step(2'b11, 2'd0, 10'h000, 1'b0, 8'h00, "R8");
      // call in the same cycle as a write: the call wins
      step(2'b01, 2'd0, 10'h2a5, 1'b0, 8'h00, "R3");
      step(2'b10, 2'd2, 10'h111, 1'b1, 8'h5a, "R8");
      step(2'b11, 2'd0, 10'h000, 1'b0, 8'h00, "R8");

      // R6: overflow, each op during the pulse is ignored
      for (int o = 0; o < 4; o++) begin
         step(2'b01, 2'd0, 10'h0f0, 1'b0, 8'h00, "R3");
         step(2'b10, 2'd1, 10'h300, 1'b0, 8'h00, "R4");
         step(2'b10, 2'd2, 10'h123, 1'b0, 8'h00, "R6");
         step(2'(o), 2'd3, 10'h2ee, 1'b0, 8'h00, "R6");
         step(2'b00, 2'd0, 10'h000, 1'b0, 8'h00, "R7");
      end
      // R6: underflow
      for (int o = 0; o < 4; o++) begin
         step(2'b01, 2'd0, 10'h077, 1'b0, 8'h00, "R3");
         step(2'b11, 2'd1, 10'h000, 1'b0, 8'h00, "R6");
         step(2'(o), 2'd2, 10'h1ab, 1'b0, 8'h00, "R6");
      end

      // R7: power-style reset keeps the return register
      step(2'b01, 2'd0, 10'h0c3, 1'b0, 8'h00, "R3");
      step(2'b10, 2'd2, 10'h010, 1'b0, 8'h00, "R4");
      do_reset("R7");
      step(2'b00, 2'd0, 10'h000, 1'b0, 8'h00, "R7");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule